// File: doc/BRIEF.md
# Replicated Multi-Port Shared Data Memory

This block is the data memory shared by a group of processor cores that run in one clock domain. Each core owns one write port and two read ports. No port ever waits and no core ever arbitrates, because the storage is replicated: every read port in the system has a private copy of the whole logical address space. The address space is cut into as many equal regions as there are cores. Region k may only be written by core k, so each copy is built from one bank per writer. The memory therefore holds 2n copies made of 2n² independently addressed banks.

A write from core k lands in its own region in every copy in the same clock. A read port looks up the region that holds its address and returns that bank's word one clock later. Placing each variable in the region of the core that produces it is done by the compiler, not by this block. A write aimed at another core's region is dropped and flagged.

Top module: `repl_mem`

## Requirements
- R1: While rst_ni is low and directly after it rises, every rd_data_o lane and every wr_err_o bit reads zero.
- R2: Region k covers addresses k*DEPTH/N_CORES up to (k+1)*DEPTH/N_CORES-1. A legal write from core k (wr_en_i[k], address in region k) is seen by all 2*N_CORES read ports, and ports that read the same address return the same word.
- R3: Read port p takes its address from rd_addr_i[p*ADDR_W +: ADDR_W] and drives the data on rd_data_o[p*DATA_W +: DATA_W] exactly one clock after the edge that samples the address. Its data stays fixed while the address is held and no writes occur.
- R4: A read of an address that is written in the same clock returns the value held before that write. The new value is returned on the following read.
- R5: A write from core k to an address outside region k leaves memory unchanged, which a later read of that address shows. wr_err_o[k] is high for exactly the one clock after that write and low after every cycle in which core k made no illegal write.
- R6: All cores may write and all read ports may read different addresses in the same clock with no stall, and each port gets the value a sequential model of the memory predicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by all cores |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | N_CORES | Write enable, bit k for core k |
| wr_addr_i | input | N_CORES*ADDR_W | Write address, core k at [k*ADDR_W +: ADDR_W] |
| wr_data_i | input | N_CORES*DATA_W | Write data, core k at [k*DATA_W +: DATA_W] |
| rd_addr_i | input | 2*N_CORES*ADDR_W | Read address, port p at [p*ADDR_W +: ADDR_W]; core c owns ports 2c and 2c+1 |
| rd_data_o | output | 2*N_CORES*DATA_W | Read data, port p at [p*DATA_W +: DATA_W] |
| wr_err_o | output | N_CORES | Write to a foreign region, bit k for core k, one clock later |

## Verification
The first pattern is a concurrent fill: every core writes its whole region while ports read back words written a cycle earlier. This separates the region split and the per-copy write fan-out. Next, every port reads the same word, which exposes a copy that missed a write. A staggered sweep of addresses with no writes checks latency and bank selection. A same-address write and read tests read-first order, and cross-region writes test that the error flag fires and that memory is left alone. A long random mix of legal and illegal writes with independent reads is then checked against a behavioural model on every clock.

// File: rtl/mcmem_pkg.sv
package mcmem_pkg;
  function automatic int unsigned region_of(input int unsigned addr, input int unsigned reg_depth);
    return addr / reg_depth;
  endfunction

  function automatic int unsigned offset_of(input int unsigned addr, input int unsigned reg_depth);
    return addr % reg_depth;
  endfunction
endpackage

// File: rtl/mcmem_bank.sv
module mcmem_bank #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned BANK_D    = 32,
  parameter int unsigned LAW       = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LAW-1:0]    waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LAW-1:0]    raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [BANK_D];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read-first: sampled before this edge's write lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/mcmem_wgate.sv
module mcmem_wgate import mcmem_pkg::*; #(
  parameter int unsigned N_CORES = 2,
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned CORE    = 0,
  parameter int unsigned AW      = 6,
  parameter int unsigned LAW     = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [AW-1:0]  addr_i,
  output logic           we_o,
  output logic [LAW-1:0] laddr_o,
  output logic           err_o
);
  localparam int unsigned BANK_D = DEPTH / N_CORES;

  logic own;

  always_comb begin
    own     = (region_of(32'(addr_i), BANK_D) == CORE);
    laddr_o = LAW'(offset_of(32'(addr_i), BANK_D));
  end

  assign we_o = en_i & own;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= en_i & ~own;
  end
endmodule

// File: rtl/mcmem_rport.sv
module mcmem_rport import mcmem_pkg::*; #(
  parameter int unsigned N_CORES = 2,
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned AW      = 6,
  parameter int unsigned LAW     = 5,
  parameter int unsigned RW      = 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [AW-1:0]                  addr_i,
  output logic [LAW-1:0]                 laddr_o,
  input  logic [N_CORES-1:0][DATA_W-1:0] blk_q_i,
  output logic [DATA_W-1:0]              rdata_o
);
  localparam int unsigned BANK_D = DEPTH / N_CORES;

  logic [RW-1:0] sel_q;
  logic          hit_q;
  int unsigned   reg_n;

  always_comb begin
    reg_n   = region_of(32'(addr_i), BANK_D);
    laddr_o = LAW'(offset_of(32'(addr_i), BANK_D));
  end

  // region is registered alongside the bank read so mux and data align
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      hit_q <= 1'b1;
    end else begin
      sel_q <= RW'(reg_n);
      hit_q <= (reg_n < N_CORES);
    end
  end

  assign rdata_o = hit_q ? blk_q_i[sel_q] : '0;
endmodule

// File: rtl/repl_mem.sv
module repl_mem #(
  parameter int unsigned N_CORES = 2,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned DEPTH   = 64,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_CORES-1:0]              wr_en_i,
  input  logic [N_CORES*ADDR_W-1:0]       wr_addr_i,
  input  logic [N_CORES*DATA_W-1:0]       wr_data_i,
  input  logic [2*N_CORES*ADDR_W-1:0]     rd_addr_i,
  output logic [2*N_CORES*DATA_W-1:0]     rd_data_o,
  output logic [N_CORES-1:0]              wr_err_o
);
  localparam int unsigned N_RD   = 2 * N_CORES;
  localparam int unsigned BANK_D = DEPTH / N_CORES;
  localparam int unsigned LAW    = (BANK_D > 1) ? $clog2(BANK_D) : 1;
  localparam int unsigned RW     = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  logic [N_CORES-1:0]                     we;
  logic [N_CORES-1:0][LAW-1:0]            wlad;
  logic [N_RD-1:0][LAW-1:0]               rlad;
  logic [N_RD-1:0][N_CORES-1:0][DATA_W-1:0] blk_q;

  for (genvar k = 0; k < N_CORES; k++) begin : g_wr
    mcmem_wgate #(
      .N_CORES(N_CORES), .DEPTH(DEPTH), .CORE(k), .AW(ADDR_W), .LAW(LAW)
    ) i_wgate (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (wr_en_i[k]),
      .addr_i  (wr_addr_i[k*ADDR_W +: ADDR_W]),
      .we_o    (we[k]),
      .laddr_o (wlad[k]),
      .err_o   (wr_err_o[k])
    );
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    mcmem_rport #(
      .N_CORES(N_CORES), .DEPTH(DEPTH), .DATA_W(DATA_W),
      .AW(ADDR_W), .LAW(LAW), .RW(RW)
    ) i_rport (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (rd_addr_i[p*ADDR_W +: ADDR_W]),
      .laddr_o (rlad[p]),
      .blk_q_i (blk_q[p]),
      .rdata_o (rd_data_o[p*DATA_W +: DATA_W])
    );

    // one bank per writer in this port's private copy
    for (genvar k = 0; k < N_CORES; k++) begin : g_bank
      mcmem_bank #(
        .DATA_W(DATA_W), .BANK_D(BANK_D), .LAW(LAW)
      ) i_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we[k]),
        .waddr_i (wlad[k]),
        .wdata_i (wr_data_i[k*DATA_W +: DATA_W]),
        .raddr_i (rlad[p]),
        .rdata_o (blk_q[p][k])
      );
    end
  end
endmodule

// File: rtl/mcmem_chk.sv
module mcmem_chk #(
  parameter int unsigned N_CORES = 2,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned DEPTH   = 64,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [N_CORES-1:0]          wr_en_i,
  input logic [N_CORES*ADDR_W-1:0]   wr_addr_i,
  input logic [2*N_CORES*ADDR_W-1:0] rd_addr_i,
  input logic [2*N_CORES*DATA_W-1:0] rd_data_o,
  input logic [N_CORES-1:0]          wr_err_o
);
  localparam int unsigned N_RD   = 2 * N_CORES;
  localparam int unsigned BANK_D = DEPTH / N_CORES;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_QUIET: assert (rd_data_o == '0 && wr_err_o == '0); // R1
    end
  end

  for (genvar k = 0; k < N_CORES; k++) begin : g_wk
    AST_ERR_ON_FOREIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i[k] && (32'(wr_addr_i[k*ADDR_W +: ADDR_W]) / BANK_D != k)) |=> wr_err_o[k]); // R5
    AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i[k] |=> !wr_err_o[k]); // R5
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rp
    AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $stable(rd_addr_i[p*ADDR_W +: ADDR_W]) && wr_en_i == '0 && $past(wr_en_i) == '0)
      |=> $stable(rd_data_o[p*DATA_W +: DATA_W])); // R3
    if (p > 0) begin : g_same
      AST_COPY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr_i[p*ADDR_W +: ADDR_W] == rd_addr_i[ADDR_W-1:0])
        |=> (rd_data_o[p*DATA_W +: DATA_W] == rd_data_o[DATA_W-1:0])); // R2
    end
  end
endmodule

bind repl_mem mcmem_chk #(
  .N_CORES(N_CORES), .DATA_W(DATA_W), .DEPTH(DEPTH)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .wr_err_o  (wr_err_o)
);

// File: tb/test_repl_mem.sv
module test_repl_mem;
  localparam int N     = 2;
  localparam int DW    = 64;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int NRD   = 2 * N;
  localparam int REG   = DEPTH / N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]      wen;
  logic [AW-1:0]     wa [N];
  logic [DW-1:0]     wd [N];
  logic [AW-1:0]     ra [NRD];
  logic [N*AW-1:0]   wa_p;
  logic [N*DW-1:0]   wd_p;
  logic [NRD*AW-1:0] ra_p;
  logic [NRD*DW-1:0] rd_p;
  logic [N-1:0]      err;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      wa_p[k*AW +: AW] = wa[k];
      wd_p[k*DW +: DW] = wd[k];
    end
    for (int p = 0; p < NRD; p++) ra_p[p*AW +: AW] = ra[p];
  end

  repl_mem #(.N_CORES(N), .DATA_W(DW), .DEPTH(DEPTH)) i_repl_mem (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wen), .wr_addr_i(wa_p), .wr_data_i(wd_p),
    .rd_addr_i(ra_p), .rd_data_o(rd_p), .wr_err_o(err)
  );

  logic [DW-1:0] ref_mem [DEPTH];
  bit            ref_ok  [DEPTH];
  int checks = 0;
  int errors = 0;
  string req = "R1";

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    wen = '0;
    for (int k = 0; k < N; k++) begin wa[k] = '0; wd[k] = '0; end
  endtask

  // reference: reads see pre-write contents; only in-region writes land
  task automatic cycle();
    logic [DW-1:0] eq [NRD];
    bit            ev [NRD];
    logic [N-1:0]  ee;
    for (int p = 0; p < NRD; p++) begin
      eq[p] = ref_mem[ra[p]];
      ev[p] = ref_ok[ra[p]];
    end
    for (int k = 0; k < N; k++) begin
      ee[k] = wen[k] && ((int'(wa[k]) / REG) != k);
      if (wen[k] && !ee[k]) begin
        ref_mem[wa[k]] = wd[k];
        ref_ok[wa[k]]  = 1'b1;
      end
    end
    @(posedge clk);
    #2;
    for (int p = 0; p < NRD; p++)
      if (ev[p]) check(rd_p[p*DW +: DW], eq[p], $sformatf("read port %0d", p));
    for (int k = 0; k < N; k++)
      check(DW'(err[k]), DW'(ee[k]), $sformatf("wr_err core %0d", k));
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    idle();
    for (int p = 0; p < NRD; p++) ra[p] = '0;
    for (int a = 0; a < DEPTH; a++) ref_ok[a] = 1'b0;
    repeat (3) @(negedge clk);
    req = "R1";
    for (int p = 0; p < NRD; p++) check(rd_p[p*DW +: DW], '0, "reset read data");
    check(DW'(err), '0, "reset error flags");
    rst_n = 1'b1;
    #1;
    for (int p = 0; p < NRD; p++) check(rd_p[p*DW +: DW], '0, "read data after reset");
    check(DW'(err), '0, "error flags after reset");
    @(negedge clk);

    // R6: every core fills its region at once, ports read last words
    req = "R6";
    for (int i = 0; i < REG; i++) begin
      wen = '1;
      for (int k = 0; k < N; k++) begin
        wa[k] = AW'(k * REG + i);
        wd[k] = {32'hC0DE_0000 + 32'(k), 32'(i) * 32'h0101_0101};
      end
      for (int p = 0; p < NRD; p++) ra[p] = AW'((p % N) * REG + ((i > 0) ? i - 1 : 0));
      cycle();
    end
    idle();

    // R2: all ports read one word, in each region, after a fresh write
    req = "R2";
    for (int k = 0; k < N; k++) begin
      wen[k] = 1'b1;
      wa[k]  = AW'(k * REG + 5);
      wd[k]  = 64'hA5A5_0000_0000_0000 | 64'(k);
      cycle();
      idle();
      for (int p = 0; p < NRD; p++) ra[p] = AW'(k * REG + 5);
      cycle();
      cycle();
    end

    // R3: staggered address sweep, no writes
    req = "R3";
    for (int i = 0; i < 16; i++) begin
      for (int p = 0; p < NRD; p++) ra[p] = AW'((i * 5 + p * 7) % DEPTH);
      cycle();
    end
    for (int i = 0; i < 3; i++) cycle();

    // R4: same-clock write and read of one address
    req = "R4";
    for (int k = 0; k < N; k++) begin
      wen[k] = 1'b1;
      wa[k]  = AW'(k * REG + 9);
      wd[k]  = 64'h4444_0000_0000_0000 | 64'(k);
      for (int p = 0; p < NRD; p++) ra[p] = AW'(k * REG + 9);
      cycle();
      idle();
      cycle();
    end

    // R5: each core writes into the other's region
    req = "R5";
    wen = '1;
    for (int k = 0; k < N; k++) begin
      wa[k] = AW'(((k + 1) % N) * REG + 3);
      wd[k] = 64'hDEAD_BEEF_0000_0000 | 64'(k);
    end
    for (int p = 0; p < NRD; p++) ra[p] = AW'((p % N) * REG + 3);
    cycle();
    idle();
    cycle();
    cycle();

    // R6: random concurrent traffic with occasional foreign writes
    req = "R6";
    for (int i = 0; i < 300; i++) begin
      for (int k = 0; k < N; k++) begin
        wen[k] = 1'($urandom_range(0, 1));
        wa[k]  = ($urandom_range(0, 9) < 8) ? AW'(k * REG + int'($urandom_range(0, REG - 1)))
                                             : AW'($urandom_range(0, DEPTH - 1));
        wd[k]  = {$urandom(), $urandom()};
      end
      for (int p = 0; p < NRD; p++) ra[p] = AW'($urandom_range(0, DEPTH - 1));
      cycle();
    end
    idle();
    cycle();

    finish_run();
  end
endmodule